// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the status/control word of a floating-point unit. Software writes the word through a plain write port. The block decodes two controls from the stored word and hands them to the arithmetic datapath: a truncating-rounding select and a flush-to-zero enable. It also records the exception flags that each arithmetic operation reports.

At every accepted operation completion the block clears the five-bit flag field. If any raw flag is set, it loads the raw flags into that field and ORs them into a sticky cause field. It then compares the cause field with an enable field. When any cause bit is enabled, the block raises a one-cycle exception request that carries a fixed vector code.

A compare operation with an ordered result leaves the word untouched. Only an unordered compare feeds its flags through. The write port, the completion strobe and the outputs are plain control and status pins, sampled or driven once per clock. The block has no valid/ready flow, so there is no back-pressure.

Top module: `fpu_status_ctl`

## Requirements
- R1: After reset, `csr_q` is 0 and `exc_req`, `rnd_trunc` and `flush_en` are 0.
- R2: A write stores `wr_data & 0x0005_FFFF`; bits 17 and 31:19 always read 0.
- R3: `rnd_trunc` is 1 exactly when `csr_q[1:0]` is 2'b01. The encodings 00, 10 and 11 give 0, which selects round-to-nearest-even.
- R4: `flush_en` follows `csr_q[18]`.
- R5: An accepted operation with nonzero `raw_flags` sets the flag field `csr_q[6:2]` to `raw_flags` and ORs `raw_flags` into the cause field `csr_q[16:12]`. `raw_flags` is laid out as bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid. The enable field `csr_q[11:7]` uses the same bit order.
- R6: An accepted operation with `raw_flags` = 0 clears `csr_q[6:2]`, leaves the cause field unchanged and raises no request.
- R7: One cycle after an accepted operation with nonzero raw flags, `exc_req` is 1 for exactly one cycle if the updated cause field ANDed with the enable field is nonzero. In that cycle `exc_vec` is 0x120. At all other times `exc_vec` is 0.
- R8: A completion with `op_is_cmp`=1 and `cmp_unord`=0 leaves `csr_q` unchanged and raises no request. An unordered compare is processed like any other operation.
- R9: When `wr_en` and `op_done` are high in the same cycle, the write takes effect and the operation is ignored: no flag update and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| op_done | input | 1 | Operation completion strobe |
| op_is_cmp | input | 1 | Completing operation is a compare |
| cmp_unord | input | 1 | Compare result was unordered |
| raw_flags | input | 5 | Raw exception flags {V,Z,O,U,I} |
| csr_q | output | 32 | Stored status/control word |
| rnd_trunc | output | 1 | Datapath rounds toward zero |
| flush_en | output | 1 | Datapath flushes denormals to zero |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 12 | Vector code of the request, 0 when idle |

## Verification
Every register result is due one clock edge after its stimulus. This covers the stored word, the flag and cause fields and the exception request pulse. The decoded rounding and flush outputs follow the stored word combinationally, in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, exactly one rising edge later. It checks the pulse's end one further cycle on with idle inputs.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int DATA_W   = 32;
  localparam int NFLAG    = 5;
  localparam int RM_LO    = 0;
  localparam int RM_W     = 2;
  localparam int FLG_LO   = RM_LO + RM_W;      // 2
  localparam int EN_LO    = FLG_LO + NFLAG;    // 7
  localparam int CAUSE_LO = EN_LO + NFLAG;     // 12
  localparam int DN_BIT   = 18;
  localparam logic [RM_W-1:0] RM_TO_ZERO = 2'b01;
  localparam logic [DATA_W-1:0] WR_MASK =
    ((DATA_W'(1) << (CAUSE_LO + NFLAG)) - DATA_W'(1)) | (DATA_W'(1) << DN_BIT);
endpackage

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode
  import fpsc_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic            dn_bit,
  output logic            rnd_trunc,
  output logic            flush_en
);
  assign rnd_trunc = (rm_field == RM_TO_ZERO);
  assign flush_en  = dn_bit;
endmodule

// File: rtl/fpsc_flag_next.sv
module fpsc_flag_next
  import fpsc_pkg::*;
(
  input  logic [DATA_W-1:0] csr_cur,
  input  logic [NFLAG-1:0]  raw_flags,
  output logic [DATA_W-1:0] csr_upd,
  output logic              trap_nxt
);
  logic             any_flag;
  logic [NFLAG-1:0] cause_upd;

  assign any_flag  = |raw_flags;
  assign cause_upd = csr_cur[CAUSE_LO +: NFLAG] | raw_flags;

  always_comb begin
    csr_upd = csr_cur;
    csr_upd[FLG_LO +: NFLAG] = raw_flags;   // cleared, then set by raw flags
    if (any_flag)
      csr_upd[CAUSE_LO +: NFLAG] = cause_upd;
  end

  assign trap_nxt = any_flag && (|(cause_upd & csr_cur[EN_LO +: NFLAG]));
endmodule

// File: rtl/fpu_status_ctl.sv
module fpu_status_ctl
  import fpsc_pkg::*;
#(
  parameter int          VEC_W    = 12,
  parameter logic [11:0] EXC_CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              op_done,
  input  logic              op_is_cmp,
  input  logic              cmp_unord,
  input  logic [4:0]        raw_flags,
  output logic [31:0]       csr_q,
  output logic              rnd_trunc,
  output logic              flush_en,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec
);
  logic              accept;
  logic [DATA_W-1:0] csr_upd;
  logic              trap_nxt;

  // ordered compares and ops colliding with a write are dropped
  assign accept = op_done && (!op_is_cmp || cmp_unord) && !wr_en;

  fpsc_flag_next u_next (
    .csr_cur  (csr_q),
    .raw_flags(raw_flags),
    .csr_upd  (csr_upd),
    .trap_nxt (trap_nxt)
  );

  fpsc_mode_decode u_mode (
    .rm_field (csr_q[RM_LO +: RM_W]),
    .dn_bit   (csr_q[DN_BIT]),
    .rnd_trunc(rnd_trunc),
    .flush_en (flush_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q   <= '0;
      exc_req <= 1'b0;
    end else begin
      if (wr_en)       csr_q <= wr_data & WR_MASK;
      else if (accept) csr_q <= csr_upd;
      exc_req <= accept && trap_nxt;
    end
  end

  assign exc_vec = exc_req ? VEC_W'(EXC_CODE) : '0;
endmodule

// File: rtl/fpsc_checker.sv
module fpsc_checker
  import fpsc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        op_done,
  input logic        op_is_cmp,
  input logic        cmp_unord,
  input logic [4:0]  raw_flags,
  input logic [31:0] csr_q,
  input logic        rnd_trunc,
  input logic        flush_en,
  input logic        exc_req,
  input logic [11:0] exc_vec
);
  a_r2_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & ~WR_MASK) == '0);
  a_r3_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_trunc == (csr_q[1:0] == 2'b01));
  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en == csr_q[18]);
  a_r6_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_is_cmp && raw_flags == '0 && !wr_en) |=>
      (csr_q[6:2] == '0) && $stable(csr_q[16:12]) && !exc_req);
  a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(op_done) && (|(csr_q[16:12] & csr_q[11:7]))
                 && exc_vec == 12'h120));
  a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> exc_vec == '0);
  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_is_cmp && !cmp_unord && !wr_en) |=>
      ($stable(csr_q) && !exc_req));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (csr_q == ($past(wr_data) & WR_MASK)) && !exc_req);
endmodule

bind fpu_status_ctl fpsc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
  .raw_flags(raw_flags), .csr_q(csr_q), .rnd_trunc(rnd_trunc),
  .flush_en(flush_en), .exc_req(exc_req), .exc_vec(exc_vec)
);

// File: tb/fpu_status_ctl_test.sv
module fpu_status_ctl_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        op_is_cmp = 1'b0;
  logic        cmp_unord = 1'b0;
  logic [4:0]  raw_flags = '0;
  logic [31:0] csr_q;
  logic        rnd_trunc, flush_en, exc_req;
  logic [11:0] exc_vec;

  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  fpu_status_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
    .raw_flags(raw_flags), .csr_q(csr_q), .rnd_trunc(rnd_trunc),
    .flush_en(flush_en), .exc_req(exc_req), .exc_vec(exc_vec)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        we;
    logic [31:0] wd;
    logic        op;
    logic        cmp;
    logic        unord;
    logic [4:0]  raw;
    logic [31:0] exp_csr;
    logic        exp_exc;
  } vec_t;

  // raw bit order {V,Z,O,U,I}; flags 6:2, enables 11:7, cause 16:12
  localparam vec_t TBL [11] = '{
    '{8'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'b00000, 32'h0005_FFFF, 1'b0}, // R2
    '{8'd2, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'b00000, 32'h0000_0000, 1'b0}, // R2
    '{8'd2, 1'b1, 32'h0000_0400, 1'b0, 1'b0, 1'b0, 5'b00000, 32'h0000_0400, 1'b0}, // R2 enable Z
    '{8'd5, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 5'b00001, 32'h0000_1404, 1'b0}, // R5 I, not enabled
    '{8'd6, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 5'b00000, 32'h0000_1400, 1'b0}, // R6
    '{8'd7, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 5'b01000, 32'h0000_9420, 1'b1}, // R7 Z trap
    '{8'd7, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 5'b00000, 32'h0000_9420, 1'b0}, // R7 one pulse
    '{8'd8, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 5'b10000, 32'h0000_9420, 1'b0}, // R8 ordered
    '{8'd8, 1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 5'b10000, 32'h0001_9440, 1'b1}, // R8 unordered
    '{8'd9, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 5'b10000, 32'h0000_0001, 1'b0}, // R9
    '{8'd5, 1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 5'b00010, 32'h0000_2009, 1'b0}  // R5 U
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; op_done = 1'b0; op_is_cmp = 1'b0; cmp_unord = 1'b0; raw_flags = '0;
  endtask

  task automatic write_csr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 csr", csr_q, 32'h0);
    check("R1 exc", {31'b0, exc_req}, 32'h0);
    check("R1 trunc", {31'b0, rnd_trunc}, 32'h0);
    check("R1 flush", {31'b0, flush_en}, 32'h0);

    foreach (TBL[i]) begin
      wr_en = TBL[i].we; wr_data = TBL[i].wd; op_done = TBL[i].op;
      op_is_cmp = TBL[i].cmp; cmp_unord = TBL[i].unord; raw_flags = TBL[i].raw;
      @(negedge clk);
      idle();
      check($sformatf("R%0d csr row %0d", TBL[i].req, i), csr_q, TBL[i].exp_csr);
      check($sformatf("R%0d exc row %0d", TBL[i].req, i), {31'b0, exc_req}, {31'b0, TBL[i].exp_exc});
      check($sformatf("R7 vec row %0d", i), {20'b0, exc_vec},
            TBL[i].exp_exc ? 32'h120 : 32'h0);
    end

    // R3: rounding encodings
    for (int e = 0; e < 4; e++) begin
      write_csr(32'(e));
      check($sformatf("R3 trunc enc %0d", e), {31'b0, rnd_trunc}, (e == 1) ? 32'h1 : 32'h0);
    end

    // R4: flush control bit 18
    write_csr(32'h0004_0000);
    check("R4 flush on", {31'b0, flush_en}, 32'h1);
    check("R4 csr", csr_q, 32'h0004_0000);
    write_csr(32'h0000_0000);
    check("R4 flush off", {31'b0, flush_en}, 32'h0);

    // R7: all enabled, consecutive trapping ops each pulse
    write_csr(32'h0000_0F80);
    op_done = 1'b1; raw_flags = 5'b00100;
    @(negedge clk);
    raw_flags = 5'b00001;
    check("R7 first pulse", {31'b0, exc_req}, 32'h1);
    @(negedge clk);
    idle();
    check("R7 second pulse", {31'b0, exc_req}, 32'h1);
    check("R5 cause accum", csr_q, 32'h0000_5F84);
    @(negedge clk);
    check("R7 pulse ends", {31'b0, exc_req}, 32'h0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 csr after reset", csr_q, 32'h0);
    check("R1 exc after reset", {31'b0, exc_req}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule